// File: doc/BRIEF.md
# Debug Halt Entry Controller

This block keeps track of the execution state of a small processor core: running, halted, single-stepping, or parked in a stop or wait low-power state. It collects every event that can put the core into halt mode and turns them into one halt request. These events are the debug pin level seen at reset, the reset causes with their own halt-after-reset enables, a background-entry command, a HALT instruction, a breakpoint trigger and a trace-buffer-full condition. Each cycle it also decides whether the debug command presented on its command port is accepted or rejected. That decision depends on the command's class, on the security and debug-enable bits, and on the core state.

The serial debug link decodes commands and presents them here as a one-cycle valid strobe with an opcode. The core reports reset causes, instruction completion, low-power requests and wake events as one-cycle strobes. The controller answers with registered accept/error pulses, a halt request pulse, a wake request pulse, the current state and a record of which halt sources caused the most recent halt entry. All outputs are registered and change on the clock edge that samples the inputs. Reset is synchronous and active high.

Top module: `debug_halt_ctrl`

## Requirements
- R1: After reset the state is run (`core_state_o` = 0) and `halt_req_o`, `cmd_acc_o`, `cmd_err_o`, `wake_req_o` and `halt_src_o` are all zero. The state codes are run=0, halt=1, stop=2, wait=3, step=4.
- R2: The always-available opcodes are 0 (control-byte read), 1 (control-byte write) and 2 (BACKGROUND). They are accepted in every state, whatever the secure and debug-enable bits are. `cmd_acc_o` pulses one cycle after `cmd_valid_i`.
- R3: While `secure_i` is 1 or `dbg_en_i` is 0, every opcode other than 0, 1 and 2 is rejected.
- R4: The non-intrusive opcodes 3 (memory), 4 (memory with status) and 5 (debug register) are accepted when unlocked and the state is run, halt or step. They are rejected in stop or wait.
- R5: The active-background opcodes 6 (CPU register), 7 (single-step) and 8 (GO) are accepted only in halt. Opcode 6 is also accepted in stop. Opcodes 9 to 15 are always rejected.
- R6: A rejected command gives a one-cycle `cmd_err_o` pulse, no `cmd_acc_o`, and leaves the state unchanged.
- R7: `rst_cause_i` bits are: 0 power-on, 1 debug-forced, 2 watchdog, 3 illegal operand, 4 illegal address. The core halts when power-on or debug-forced is strobed while `dbg_pin_i` is low. It also halts when cause k+1 is strobed with `halt_en_i[k]` set. `halt_src_o` bits: 0 pin at power-on, 1 pin after forced reset, 2 to 5 enabled causes 1 to 4.
- R8: An accepted BACKGROUND moves the core to halt on the next clock (`halt_src_o` bit 6). From stop or wait it also pulses `wake_req_o`.
- R9: A HALT instruction strobe halts a running or stepping core only when `dbg_en_i` is 1 (`halt_src_o` bit 7).
- R10: A breakpoint trigger halts the core when `bkpt_halt_i` is 1 (bit 8). Trace-buffer-full halts it only when `rec_mode_i` is 01 or 11 (bit 9).
- R11: An accepted GO in halt moves the state to run on the next clock. An accepted single-step moves it to step. The state stays in step until one `instr_done_i` strobe and then returns to halt without a `halt_req_o` pulse.
- R12: Halt sources that arrive in the same cycle give a single one-cycle `halt_req_o` pulse, and `halt_src_o` holds all of them. Sources are ignored while halted.
- R13: In run, `stop_req_i` moves the state to stop and `wait_req_i` moves it to wait, with stop winning if both are present. From stop or wait, `wake_evt_i` returns the state to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_cause_i | input | 5 | Reset-cause strobes (power-on, forced, watchdog, illegal operand, illegal address) |
| halt_en_i | input | 4 | Halt-after-reset enables for causes 1 to 4 |
| dbg_pin_i | input | 1 | Debug pin level |
| cmd_valid_i | input | 1 | Decoded debug command strobe |
| cmd_op_i | input | 4 | Debug command opcode |
| halt_instr_i | input | 1 | HALT instruction executed |
| instr_done_i | input | 1 | Instruction completed |
| bkpt_trig_i | input | 1 | Breakpoint trigger |
| bkpt_halt_i | input | 1 | Breakpoint response is halt |
| tbuf_full_i | input | 1 | Trace buffer full |
| rec_mode_i | input | 2 | Trace recording mode |
| secure_i | input | 1 | Device secure |
| dbg_en_i | input | 1 | Debug interface enabled |
| stop_req_i | input | 1 | Core requests stop |
| wait_req_i | input | 1 | Core requests wait |
| wake_evt_i | input | 1 | Wake event from low power |
| core_state_o | output | 3 | Core state code |
| halt_req_o | output | 1 | Halt entry pulse |
| cmd_acc_o | output | 1 | Command accepted pulse |
| cmd_err_o | output | 1 | Command rejected pulse |
| wake_req_o | output | 1 | Wake request pulse |
| halt_src_o | output | 10 | Sources of the last halt entry |

## Verification
The bench builds the block with its default trace mask, in which only recording modes 01 and 11 halt. That brings all four recording-mode values within reach, two halting and two not. The command table runs the acceptance matrix in the run state across the secure and enable combinations. Directed sequences then reach halt, step, stop and wait, so that state-dependent acceptance, wake from low power, reset-cause gating by pin level and enables, and the merging of coincident halt sources are all observed at the ports.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    localparam int ST_W    = 3;
    localparam int OP_W    = 4;
    localparam int REC_W   = 2;
    localparam int NCAUSE  = 5;
    localparam int NEN     = NCAUSE - 1;
    localparam int SRC_W   = 10;

    // halt source bit positions
    localparam int SRC_PIN_POR   = 0;
    localparam int SRC_PIN_FRC   = 1;
    localparam int SRC_EN_BASE   = 2;
    localparam int SRC_BGND      = SRC_EN_BASE + NEN;
    localparam int SRC_INSTR     = SRC_BGND + 1;
    localparam int SRC_BKPT      = SRC_INSTR + 1;
    localparam int SRC_TRACE     = SRC_BKPT + 1;

    // reset cause bit positions
    localparam int RC_POR    = 0;
    localparam int RC_FORCED = 1;

    typedef enum logic [ST_W-1:0] {
        CS_RUN  = 3'd0,
        CS_HALT = 3'd1,
        CS_STOP = 3'd2,
        CS_WAIT = 3'd3,
        CS_STEP = 3'd4
    } core_st_e;

    typedef enum logic [1:0] {
        CC_ALWAYS  = 2'd0,
        CC_NONINTR = 2'd1,
        CC_ACTIVE  = 2'd2,
        CC_NONE    = 2'd3
    } cmd_cls_e;

    localparam logic [OP_W-1:0] OP_RD_CTRL = 4'd0;
    localparam logic [OP_W-1:0] OP_WR_CTRL = 4'd1;
    localparam logic [OP_W-1:0] OP_BGND    = 4'd2;
    localparam logic [OP_W-1:0] OP_MEM     = 4'd3;
    localparam logic [OP_W-1:0] OP_MEM_ST  = 4'd4;
    localparam logic [OP_W-1:0] OP_DREG    = 4'd5;
    localparam logic [OP_W-1:0] OP_CPUREG  = 4'd6;
    localparam logic [OP_W-1:0] OP_STEP    = 4'd7;
    localparam logic [OP_W-1:0] OP_GO      = 4'd8;

    function automatic cmd_cls_e op_class(input logic [OP_W-1:0] op);
        case (op)
            OP_RD_CTRL, OP_WR_CTRL, OP_BGND: return CC_ALWAYS;
            OP_MEM, OP_MEM_ST, OP_DREG:      return CC_NONINTR;
            OP_CPUREG, OP_STEP, OP_GO:       return CC_ACTIVE;
            default:                         return CC_NONE;
        endcase
    endfunction

    function automatic logic is_low_power(input core_st_e st);
        return (st == CS_STOP) || (st == CS_WAIT);
    endfunction

endpackage

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate
    import dbg_halt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid_i,
    input  logic [OP_W-1:0] cmd_op_i,
    input  logic            secure_i,
    input  logic            dbg_en_i,
    input  core_st_e        state_i,
    output logic            cmd_acc_o,
    output logic            cmd_err_o,
    output logic            go_o,
    output logic            step_o,
    output logic            bgnd_o
);

    cmd_cls_e cls;
    logic     unlocked;
    logic     ok;

    always_comb begin
        cls      = op_class(cmd_op_i);
        unlocked = !secure_i && dbg_en_i;
        case (cls)
            CC_ALWAYS:  ok = 1'b1;
            CC_NONINTR: ok = unlocked && !is_low_power(state_i);
            CC_ACTIVE:  ok = unlocked && ((state_i == CS_HALT) ||
                             (cmd_op_i == OP_CPUREG && state_i == CS_STOP));
            default:    ok = 1'b0;
        endcase
    end

    assign go_o   = cmd_valid_i && ok && (cmd_op_i == OP_GO);
    assign step_o = cmd_valid_i && ok && (cmd_op_i == OP_STEP);
    assign bgnd_o = cmd_valid_i && ok && (cmd_op_i == OP_BGND);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_acc_o <= 1'b0;
            cmd_err_o <= 1'b0;
        end else begin
            cmd_acc_o <= cmd_valid_i && ok;
            cmd_err_o <= cmd_valid_i && !ok;
        end
    end

    AST_ALWAYS_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_op_i <= OP_BGND) |=> cmd_acc_o); // R2

    AST_LOCKED_REJECT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && (secure_i || !dbg_en_i) && cmd_op_i > OP_BGND)
        |=> (cmd_err_o && !cmd_acc_o)); // R3

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(cmd_acc_o && cmd_err_o)); // R6

    AST_NO_CMD_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid_i |=> (!cmd_err_o && !cmd_acc_o)); // R6

    AST_LOWPOWER_NONINTR: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && is_low_power(state_i) && cmd_op_i >= OP_MEM && cmd_op_i <= OP_DREG)
        |=> cmd_err_o); // R4

endmodule

// File: rtl/dbg_halt_srcs.sv
module dbg_halt_srcs
    import dbg_halt_pkg::*;
#(
    parameter logic [2**REC_W-1:0] TRACE_HALT_MODES = 4'b1010
) (
    input  core_st_e          state_i,
    input  logic [NCAUSE-1:0] rst_cause_i,
    input  logic [NEN-1:0]    halt_en_i,
    input  logic              dbg_pin_i,
    input  logic              bgnd_i,
    input  logic              halt_instr_i,
    input  logic              dbg_en_i,
    input  logic              bkpt_trig_i,
    input  logic              bkpt_halt_i,
    input  logic              tbuf_full_i,
    input  logic [REC_W-1:0]  rec_mode_i,
    output logic [SRC_W-1:0]  src_o
);

    logic [NEN-1:0] en_hit;

    for (genvar k = 0; k < NEN; k++) begin : g_cause
        assign en_hit[k] = rst_cause_i[k+1] && halt_en_i[k];
    end

    logic active;
    logic executing;

    always_comb begin
        active    = (state_i != CS_HALT);
        executing = (state_i == CS_RUN) || (state_i == CS_STEP);
        src_o = '0;
        src_o[SRC_PIN_POR] = rst_cause_i[RC_POR] && !dbg_pin_i;
        src_o[SRC_PIN_FRC] = rst_cause_i[RC_FORCED] && !dbg_pin_i;
        src_o[SRC_EN_BASE +: NEN] = en_hit;
        src_o[SRC_BGND]  = bgnd_i;
        src_o[SRC_INSTR] = halt_instr_i && dbg_en_i && executing;
        src_o[SRC_BKPT]  = bkpt_trig_i && bkpt_halt_i && executing;
        src_o[SRC_TRACE] = tbuf_full_i && TRACE_HALT_MODES[rec_mode_i] && executing;
        if (!active) src_o = '0;
    end

endmodule

// File: rtl/dbg_core_fsm.sv
module dbg_core_fsm
    import dbg_halt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_i,
    input  logic             go_i,
    input  logic             step_i,
    input  logic             instr_done_i,
    input  logic             stop_req_i,
    input  logic             wait_req_i,
    input  logic             wake_evt_i,
    output core_st_e         state_o,
    output logic             halt_req_o,
    output logic             wake_req_o,
    output logic [SRC_W-1:0] halt_src_o
);

    core_st_e state_q;
    logic     any_src;

    assign any_src = |src_i;
    assign state_o = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CS_RUN;
            halt_req_o <= 1'b0;
            wake_req_o <= 1'b0;
            halt_src_o <= '0;
        end else begin
            halt_req_o <= 1'b0;
            wake_req_o <= 1'b0;
            if (any_src) begin
                state_q    <= CS_HALT;
                halt_req_o <= 1'b1;
                halt_src_o <= src_i;
                wake_req_o <= src_i[SRC_BGND] && is_low_power(state_q);
            end else begin
                case (state_q)
                    CS_HALT: begin
                        if (go_i)        state_q <= CS_RUN;
                        else if (step_i) state_q <= CS_STEP;
                    end
                    CS_STEP: if (instr_done_i) state_q <= CS_HALT;
                    CS_RUN: begin
                        if (stop_req_i)      state_q <= CS_STOP;
                        else if (wait_req_i) state_q <= CS_WAIT;
                    end
                    CS_STOP, CS_WAIT: if (wake_evt_i) state_q <= CS_RUN;
                    default: state_q <= CS_RUN;
                endcase
            end
        end
    end

    AST_HALT_REQ_IN_HALT: assert property (@(posedge clk) disable iff (rst)
        halt_req_o |-> (state_q == CS_HALT && halt_src_o != '0)); // R12

    AST_HALT_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        halt_req_o |=> !halt_req_o); // R12

    AST_WAKE_TO_HALT: assert property (@(posedge clk) disable iff (rst)
        wake_req_o |-> (state_q == CS_HALT && halt_src_o[SRC_BGND])); // R8

    AST_GO_RUNS: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_HALT && go_i) |=> state_q == CS_RUN); // R11

    AST_STEP_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_STEP && instr_done_i && !any_src) |=> (state_q == CS_HALT && !halt_req_o)); // R11

    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_RUN && stop_req_i && !any_src) |=> state_q == CS_STOP); // R13

endmodule

// File: rtl/debug_halt_ctrl.sv
module debug_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter logic [2**REC_W-1:0] TRACE_HALT_MODES = 4'b1010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCAUSE-1:0] rst_cause_i,
    input  logic [NEN-1:0]    halt_en_i,
    input  logic              dbg_pin_i,
    input  logic              cmd_valid_i,
    input  logic [OP_W-1:0]   cmd_op_i,
    input  logic              halt_instr_i,
    input  logic              instr_done_i,
    input  logic              bkpt_trig_i,
    input  logic              bkpt_halt_i,
    input  logic              tbuf_full_i,
    input  logic [REC_W-1:0]  rec_mode_i,
    input  logic              secure_i,
    input  logic              dbg_en_i,
    input  logic              stop_req_i,
    input  logic              wait_req_i,
    input  logic              wake_evt_i,
    output logic [ST_W-1:0]   core_state_o,
    output logic              halt_req_o,
    output logic              cmd_acc_o,
    output logic              cmd_err_o,
    output logic              wake_req_o,
    output logic [SRC_W-1:0]  halt_src_o
);

    core_st_e         state;
    logic             go, step, bgnd;
    logic [SRC_W-1:0] src;

    dbg_cmd_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_i),
        .secure_i    (secure_i),
        .dbg_en_i    (dbg_en_i),
        .state_i     (state),
        .cmd_acc_o   (cmd_acc_o),
        .cmd_err_o   (cmd_err_o),
        .go_o        (go),
        .step_o      (step),
        .bgnd_o      (bgnd)
    );

    dbg_halt_srcs #(.TRACE_HALT_MODES(TRACE_HALT_MODES)) u_srcs (
        .state_i      (state),
        .rst_cause_i  (rst_cause_i),
        .halt_en_i    (halt_en_i),
        .dbg_pin_i    (dbg_pin_i),
        .bgnd_i       (bgnd),
        .halt_instr_i (halt_instr_i),
        .dbg_en_i     (dbg_en_i),
        .bkpt_trig_i  (bkpt_trig_i),
        .bkpt_halt_i  (bkpt_halt_i),
        .tbuf_full_i  (tbuf_full_i),
        .rec_mode_i   (rec_mode_i),
        .src_o        (src)
    );

    dbg_core_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .src_i        (src),
        .go_i         (go),
        .step_i       (step),
        .instr_done_i (instr_done_i),
        .stop_req_i   (stop_req_i),
        .wait_req_i   (wait_req_i),
        .wake_evt_i   (wake_evt_i),
        .state_o      (state),
        .halt_req_o   (halt_req_o),
        .wake_req_o   (wake_req_o),
        .halt_src_o   (halt_src_o)
    );

    assign core_state_o = state;

    AST_INSTR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (!dbg_en_i && halt_instr_i && state == CS_RUN && rst_cause_i == '0 && !bgnd
         && !bkpt_trig_i && !tbuf_full_i) |=> !halt_req_o); // R9

    AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && (secure_i || !dbg_en_i) && cmd_op_i > OP_BGND && src == '0
         && state == CS_HALT) |=> core_state_o == $past(core_state_o)); // R6

endmodule

// File: tb/debug_halt_ctrl_tb.sv
module debug_halt_ctrl_tb;

    logic       clk = 0;
    logic       rst = 1;
    logic [4:0] rst_cause = '0;
    logic [3:0] halt_en = '0;
    logic       dbg_pin = 1;
    logic       cmd_valid = 0;
    logic [3:0] cmd_op = '0;
    logic       halt_instr = 0, instr_done = 0, bkpt_trig = 0, bkpt_halt = 0;
    logic       tbuf_full = 0;
    logic [1:0] rec_mode = '0;
    logic       secure = 0, dbg_en = 0;
    logic       stop_req = 0, wait_req = 0, wake_evt = 0;
    logic [2:0] core_state;
    logic       halt_req, cmd_acc, cmd_err, wake_req;
    logic [9:0] halt_src;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    debug_halt_ctrl u_dut (
        .clk(clk), .rst(rst), .rst_cause_i(rst_cause), .halt_en_i(halt_en),
        .dbg_pin_i(dbg_pin), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .halt_instr_i(halt_instr), .instr_done_i(instr_done),
        .bkpt_trig_i(bkpt_trig), .bkpt_halt_i(bkpt_halt),
        .tbuf_full_i(tbuf_full), .rec_mode_i(rec_mode),
        .secure_i(secure), .dbg_en_i(dbg_en), .stop_req_i(stop_req),
        .wait_req_i(wait_req), .wake_evt_i(wake_evt),
        .core_state_o(core_state), .halt_req_o(halt_req),
        .cmd_acc_o(cmd_acc), .cmd_err_o(cmd_err), .wake_req_o(wake_req),
        .halt_src_o(halt_src)
    );

    // {secure, dbg_en, opcode[3:0], expected accept}, all issued in run state
    localparam int NV = 14;
    localparam logic [6:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'd0,  1'b1},
        {1'b1, 1'b0, 4'd1,  1'b1},
        {1'b1, 1'b1, 4'd0,  1'b1},
        {1'b0, 1'b1, 4'd3,  1'b1},
        {1'b0, 1'b1, 4'd4,  1'b1},
        {1'b0, 1'b1, 4'd5,  1'b1},
        {1'b1, 1'b1, 4'd3,  1'b0},
        {1'b0, 1'b0, 4'd4,  1'b0},
        {1'b1, 1'b0, 4'd5,  1'b0},
        {1'b0, 1'b1, 4'd6,  1'b0},
        {1'b0, 1'b1, 4'd7,  1'b0},
        {1'b0, 1'b1, 4'd8,  1'b0},
        {1'b0, 1'b1, 4'd9,  1'b0},
        {1'b0, 1'b1, 4'd15, 1'b0}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(logic [3:0] op);
        cmd_valid = 1; cmd_op = op;
        tick();
        cmd_valid = 0; cmd_op = '0;
    endtask

    task automatic go_run();
        send(4'd8);
        chk("R11 GO to run", core_state, 0);
    endtask

    task automatic cause(logic [4:0] c);
        rst_cause = c;
        tick();
        rst_cause = '0;
    endtask

    function automatic string vtag(logic s, logic e, logic [3:0] op);
        if (op <= 2) return "R2 always class";
        if (s || !e) return "R3 locked";
        if (op <= 5) return "R4 non-intrusive";
        return "R5 active/undefined";
    endfunction

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 state", core_state, 0);
        chk("R1 halt_req", halt_req, 0);
        chk("R1 acc", cmd_acc, 0);
        chk("R1 err", cmd_err, 0);
        chk("R1 wake", wake_req, 0);
        chk("R1 src", halt_src, 0);

        // acceptance table in run state
        for (int i = 0; i < NV; i++) begin
            secure = VEC[i][6];
            dbg_en = VEC[i][5];
            send(VEC[i][4:1]);
            chk(vtag(VEC[i][6], VEC[i][5], VEC[i][4:1]), cmd_acc, VEC[i][0]);
            chk(vtag(VEC[i][6], VEC[i][5], VEC[i][4:1]), cmd_err, !VEC[i][0]);
            chk("R6 state kept", core_state, 0);
        end
        secure = 0; dbg_en = 1;
        tick();
        chk("R6 err pulse ends", cmd_err, 0);

        // R9 HALT instruction gated by enable
        dbg_en = 0; halt_instr = 1; tick(); halt_instr = 0;
        chk("R9 disabled no halt", core_state, 0);
        chk("R9 disabled no req", halt_req, 0);
        dbg_en = 1; halt_instr = 1; tick(); halt_instr = 0;
        chk("R9 halt", core_state, 1);
        chk("R9 req", halt_req, 1);
        chk("R9 src", halt_src, 10'h080);
        tick();
        chk("R12 req one cycle", halt_req, 0);

        // R4/R5 in halt
        send(4'd3); chk("R4 halt mem", cmd_acc, 1);
        send(4'd6); chk("R5 halt cpureg", cmd_acc, 1);
        secure = 1; send(4'd8);
        chk("R6 locked GO err", cmd_err, 1);
        chk("R6 locked GO state", core_state, 1);
        secure = 0;
        go_run();

        // R10 breakpoint
        bkpt_trig = 1; bkpt_halt = 0; tick(); bkpt_trig = 0;
        chk("R10 bkpt no-halt response", core_state, 0);
        bkpt_trig = 1; bkpt_halt = 1; tick(); bkpt_trig = 0; bkpt_halt = 0;
        chk("R10 bkpt halt", core_state, 1);
        chk("R10 bkpt src", halt_src, 10'h100);
        go_run();

        // R10 trace modes
        rec_mode = 2'b00; tbuf_full = 1; tick(); tbuf_full = 0;
        chk("R10 trace mode 00", core_state, 0);
        rec_mode = 2'b10; tbuf_full = 1; tick(); tbuf_full = 0;
        chk("R10 trace mode 10", core_state, 0);
        rec_mode = 2'b01; tbuf_full = 1; tick(); tbuf_full = 0;
        chk("R10 trace mode 01", core_state, 1);
        chk("R10 trace src", halt_src, 10'h200);
        go_run();
        rec_mode = 2'b11; tbuf_full = 1; tick(); tbuf_full = 0;
        chk("R10 trace mode 11", core_state, 1);

        // R11 single step
        send(4'd7);
        chk("R11 step accepted", cmd_acc, 1);
        chk("R11 in step", core_state, 4);
        tick();
        chk("R11 step waits", core_state, 4);
        instr_done = 1; tick(); instr_done = 0;
        chk("R11 step back to halt", core_state, 1);
        chk("R11 no halt_req on step return", halt_req, 0);
        go_run();

        // R13 stop, R4/R5/R8 in stop
        stop_req = 1; tick(); stop_req = 0;
        chk("R13 stop", core_state, 2);
        send(4'd3); chk("R4 stop mem rejected", cmd_err, 1);
        send(4'd6); chk("R5 stop cpureg accepted", cmd_acc, 1);
        send(4'd8); chk("R5 stop GO rejected", cmd_err, 1);
        chk("R6 stop kept", core_state, 2);
        send(4'd2);
        chk("R8 bgnd from stop", core_state, 1);
        chk("R8 wake", wake_req, 1);
        chk("R8 src", halt_src, 10'h040);
        tick();
        chk("R8 wake pulse ends", wake_req, 0);
        go_run();
        stop_req = 1; wait_req = 1; tick(); stop_req = 0; wait_req = 0;
        chk("R13 stop wins", core_state, 2);
        wake_evt = 1; tick(); wake_evt = 0;
        chk("R13 wake to run", core_state, 0);
        wait_req = 1; tick(); wait_req = 0;
        chk("R13 wait", core_state, 3);
        send(4'd2);
        chk("R8 bgnd from wait", core_state, 1);
        chk("R8 wake from wait", wake_req, 1);
        go_run();

        // R7 reset causes
        dbg_pin = 1; cause(5'b00001);
        chk("R7 por pin high", core_state, 0);
        dbg_pin = 0; cause(5'b00001);
        chk("R7 por pin low", core_state, 1);
        chk("R7 por src", halt_src, 10'h001);
        go_run();
        cause(5'b00010);
        chk("R7 forced pin low src", halt_src, 10'h002);
        go_run();
        dbg_pin = 1; cause(5'b00010);
        chk("R7 forced no enable", core_state, 0);
        halt_en = 4'b0001; cause(5'b00010);
        chk("R7 forced enabled", halt_src, 10'h004);
        go_run();
        halt_en = 4'b0000; cause(5'b00100);
        chk("R7 watchdog no enable", core_state, 0);
        halt_en = 4'b0010; cause(5'b00100);
        chk("R7 watchdog enabled", halt_src, 10'h008);
        go_run();
        halt_en = 4'b0100; cause(5'b01000);
        chk("R7 illegal operand", halt_src, 10'h010);
        go_run();
        halt_en = 4'b1000; cause(5'b10000);
        chk("R7 illegal address", halt_src, 10'h020);
        go_run();
        halt_en = 4'b0000;

        // R12 merged sources
        rec_mode = 2'b01;
        halt_instr = 1; bkpt_trig = 1; bkpt_halt = 1; tbuf_full = 1;
        tick();
        halt_instr = 0; bkpt_trig = 0; bkpt_halt = 0; tbuf_full = 0;
        chk("R12 merged req", halt_req, 1);
        chk("R12 merged src", halt_src, 10'h380);
        tick();
        chk("R12 single pulse", halt_req, 0);
        halt_instr = 1; tick(); halt_instr = 0;
        chk("R12 ignored while halted", halt_req, 0);
        chk("R12 src kept", halt_src, 10'h380);
        go_run();

        // R2/R8 background while secure
        secure = 1; send(4'd2);
        chk("R2 secure bgnd accepted", cmd_acc, 1);
        chk("R8 secure bgnd halts", core_state, 1);
        chk("R8 no wake from run", wake_req, 0);
        secure = 0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule